// File: doc/BRIEF.md
# Voltage Transition Sequencer

This block carries out one operating-point change for a single supply domain and then lets the core clock divider move to its new setting. Software programs the block over a simple register bus. It sets two enable bits in a control word, a window of legal voltage codes, and an interrupt mask. It then issues a request word that carries a target voltage code and a new divider value. The sequencer sends the target to an external regulator and waits for that regulator to report a settled supply. Only then does it load the divider register, and after that it raises a change-done status.

Every status bit is sticky and is cleared by writing one to it. The interrupt line is the OR of all status bits, each gated by its own enable. A request whose target lies outside the programmed window never starts. Instead it sets a bounds status. A request that arrives while a change is still running is dropped and sets a sticky error status.

The state machine has five states: IDLE, VOLT_CHANGE, WAIT_STABLE, CLK_UPDATE and DONE. The transitions are:
- IDLE to VOLT_CHANGE on an accepted request.
- VOLT_CHANGE to WAIT_STABLE unconditionally.
- WAIT_STABLE to CLK_UPDATE when the settled flag is sampled high.
- CLK_UPDATE to DONE unconditionally.
- DONE to IDLE unconditionally.

IDLE stays in IDLE on a request that is rejected or ignored.

Top module: `vtrans_seq`

## Requirements
- R1: After reset the following hold:
  - The control word, the interrupt enables and the status are 0.
  - The window reads 0x00FF0000 (minimum 0x00, maximum 0xFF).
  - The divider output is 1.
  - `irq` is 0 and `volt_req` is 0.
- R2: The control word (address 0) keeps two bits: bit 0, the sequencer enable, and bit 11, the adaptive-voltage enable. A request is acted on only when both bits are 1. Otherwise it is ignored: there is no `volt_req` pulse and no status change, and the request word readback is unchanged.
- R3: A write to the request word (address 3) carries the target code in bits [7:0] and the divider in bits [20:16]. If the request is accepted, `volt_req` is high for exactly the one cycle that follows the write. In that cycle `volt_code` equals the target, and it holds that value until the next accepted request.
- R4: The sequencer waits in WAIT_STABLE for as many cycles as `volt_stable` stays low. A high `volt_stable` in any other state has no effect.
- R5: `clk_div` keeps its old value until `volt_stable` has been sampled high in WAIT_STABLE. It takes the requested divider one cycle after that sampling edge.
- R6: The change-done status (bit 10 of the status word, address 2) reads 1 starting one cycle after `clk_div` takes its new value.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: `irq` is high exactly when some status bit and the matching enable bit (address 1) are both 1. The enable positions are the same as the status positions: bit 5 error, bit 10 done, bit 22 bounds.
- R9: The window word (address 4) holds the minimum in bits [7:0] and the maximum in bits [23:16], both inclusive.
  - An enabled request whose target is outside the window sets bounds status bit 22 and starts no change.
  - A target equal to a limit is accepted.
- R10: A request written while the sequencer is not in IDLE is ignored: target and divider are unchanged. It sets the sticky error status bit 5.
- R11: When a status bit is set and cleared by software in the same cycle, it ends up set.
- R12: Address 5 reads back the current divider. Address 3 reads back the last accepted target and divider. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| volt_stable | input | 1 | Regulator reports a settled supply |
| volt_req | output | 1 | One-cycle pulse asking the regulator for a new level |
| volt_code | output | 8 | Target voltage code sent to the regulator |
| clk_div | output | 5 | Core clock output divider setting |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach from the ports is the collision in R11. A software clear of the done bit has to land in the single DONE cycle, which is the cycle in which the done status is being set. The stimulus counts edges from the request write: one edge into VOLT_CHANGE, one into WAIT_STABLE, a settled pulse into CLK_UPDATE, and one more edge into DONE. It then places the write-one-to-clear exactly there. A second case reaches the busy rejection of R10 by writing a new request while the regulator is held unsettled. Boundary targets equal to each window limit exercise the inclusive comparison.

// File: rtl/vts_pkg.sv
package vts_pkg;

    typedef enum logic [2:0] {
        S_IDLE        = 3'd0,
        S_VOLT_CHANGE = 3'd1,
        S_WAIT_STABLE = 3'd2,
        S_CLK_UPDATE  = 3'd3,
        S_DONE        = 3'd4
    } seq_state_t;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_IEN    = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd2;
    localparam logic [ADDR_W-1:0] A_REQ    = 3'd3;
    localparam logic [ADDR_W-1:0] A_LIMIT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CLKDIV = 3'd5;

    localparam int B_SEQ_EN = 0;
    localparam int B_AVS_EN = 11;
    localparam int B_ERR    = 5;
    localparam int B_DONE   = 10;
    localparam int B_BOUNDS = 22;

    localparam int HI_FIELD_LSB = 16;

    localparam logic [31:0] IRQ_MASK  = (32'd1 << B_ERR) | (32'd1 << B_DONE) | (32'd1 << B_BOUNDS);
    localparam logic [31:0] CTRL_MASK = (32'd1 << B_SEQ_EN) | (32'd1 << B_AVS_EN);

endpackage

// File: rtl/vts_range_chk.sv
module vts_range_chk #(
    parameter int VCODE_W = 8
) (
    input  logic [VCODE_W-1:0] code,
    input  logic [VCODE_W-1:0] vmin,
    input  logic [VCODE_W-1:0] vmax,
    output logic               in_range
);

    logic above_min;
    logic below_max;

    always_comb begin
        above_min = (code >= vmin);
        below_max = (code <= vmax);
        in_range  = above_min && below_max;
    end

endmodule

// File: rtl/vts_fsm.sv
module vts_fsm
    import vts_pkg::*;
#(
    parameter int VCODE_W = 8,
    parameter int DIV_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_wr,
    input  logic [VCODE_W-1:0] req_code,
    input  logic [DIV_W-1:0]   req_div,
    input  logic               seq_enable,
    input  logic               in_range,
    input  logic               volt_stable,
    output logic               volt_req,
    output logic [VCODE_W-1:0] tgt_q,
    output logic [DIV_W-1:0]   div_pend_q,
    output logic               div_load,
    output logic               done_set,
    output logic               bounds_set,
    output logic               err_set
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       accept;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        accept  = (state_q == S_IDLE) && req_wr && seq_enable && in_range;
        state_d = state_q;
        unique case (state_q)
            S_IDLE:        if (accept) state_d = S_VOLT_CHANGE;
            S_VOLT_CHANGE: state_d = S_WAIT_STABLE;
            S_WAIT_STABLE: if (volt_stable) state_d = S_CLK_UPDATE;
            S_CLK_UPDATE:  state_d = S_DONE;
            S_DONE:        state_d = S_IDLE;
            default:       state_d = S_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        volt_req   = (state_q == S_VOLT_CHANGE);
        div_load   = (state_q == S_CLK_UPDATE);
        done_set   = (state_q == S_DONE);
        bounds_set = (state_q == S_IDLE) && req_wr && seq_enable && !in_range;
        err_set    = (state_q != S_IDLE) && req_wr;
    end

    // captured request payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q      <= '0;
            div_pend_q <= '0;
        end else if (accept) begin
            tgt_q      <= req_code;
            div_pend_q <= req_div;
        end
    end

    p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        volt_req |=> !volt_req);

    p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_STABLE && !volt_stable) |=> (state_q == S_WAIT_STABLE));

    p_bounds_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bounds_set |=> (!volt_req && state_q == S_IDLE));

    p_busy_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && state_q != S_IDLE) |=> $stable(tgt_q));

endmodule

// File: rtl/vts_regfile.sv
module vts_regfile
    import vts_pkg::*;
#(
    parameter int VCODE_W = 8,
    parameter int DIV_W   = 5,
    parameter int DIV_RST = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [VCODE_W-1:0] tgt_q,
    input  logic [DIV_W-1:0]   div_pend_q,
    input  logic               div_load,
    input  logic               done_set,
    input  logic               bounds_set,
    input  logic               err_set,
    output logic               req_wr,
    output logic               seq_enable,
    output logic [VCODE_W-1:0] vmin,
    output logic [VCODE_W-1:0] vmax,
    output logic [DIV_W-1:0]   clk_div,
    output logic               irq
);

    logic [31:0] ctrl_q;
    logic [31:0] en_q;
    logic [31:0] stat_q;
    logic [31:0] stat_d;
    logic [31:0] set_vec;
    logic [31:0] clr_vec;
    logic        wr_ctrl, wr_ien, wr_stat, wr_lim;

    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == A_CTRL);
        wr_ien  = bus_wr && (bus_addr == A_IEN);
        wr_stat = bus_wr && (bus_addr == A_STAT);
        wr_lim  = bus_wr && (bus_addr == A_LIMIT);
        req_wr  = bus_wr && (bus_addr == A_REQ);
    end

    always_comb begin
        set_vec           = '0;
        set_vec[B_ERR]    = err_set;
        set_vec[B_DONE]   = done_set;
        set_vec[B_BOUNDS] = bounds_set;
        clr_vec           = wr_stat ? (bus_wdata & IRQ_MASK) : '0;
        // a set in the same cycle overrides the clear
        stat_d            = (stat_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            en_q    <= '0;
            stat_q  <= '0;
            vmin    <= '0;
            vmax    <= '1;
            clk_div <= DIV_W'(DIV_RST);
        end else begin
            stat_q <= stat_d;
            if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
            if (wr_ien)  en_q   <= bus_wdata & IRQ_MASK;
            if (wr_lim) begin
                vmin <= bus_wdata[VCODE_W-1:0];
                vmax <= bus_wdata[HI_FIELD_LSB +: VCODE_W];
            end
            if (div_load) clk_div <= div_pend_q;
        end
    end

    always_comb begin
        seq_enable = ctrl_q[B_SEQ_EN] && ctrl_q[B_AVS_EN];
        irq        = |(stat_q & en_q);
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:   bus_rdata = ctrl_q;
            A_IEN:    bus_rdata = en_q;
            A_STAT:   bus_rdata = stat_q;
            A_REQ: begin
                bus_rdata[VCODE_W-1:0]           = tgt_q;
                bus_rdata[HI_FIELD_LSB +: DIV_W] = div_pend_q;
            end
            A_LIMIT: begin
                bus_rdata[VCODE_W-1:0]             = vmin;
                bus_rdata[HI_FIELD_LSB +: VCODE_W] = vmax;
            end
            A_CLKDIV: bus_rdata[DIV_W-1:0] = clk_div;
            default:  bus_rdata = '0;
        endcase
    end

    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> stat_q[B_DONE]);

    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && bus_wdata[B_BOUNDS] && !bounds_set) |=> !stat_q[B_BOUNDS]);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[B_ERR] && !(wr_stat && bus_wdata[B_ERR])) |=> stat_q[B_ERR]);

endmodule

// File: rtl/vtrans_seq.sv
module vtrans_seq
    import vts_pkg::*;
#(
    parameter int VCODE_W = 8,
    parameter int DIV_W   = 5,
    parameter int DIV_RST = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [2:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               volt_stable,
    output logic               volt_req,
    output logic [VCODE_W-1:0] volt_code,
    output logic [DIV_W-1:0]   clk_div,
    output logic               irq
);

    logic               req_wr;
    logic               seq_enable;
    logic               in_range;
    logic [VCODE_W-1:0] vmin, vmax;
    logic [VCODE_W-1:0] tgt_q;
    logic [DIV_W-1:0]   div_pend_q;
    logic               div_load, done_set, bounds_set, err_set;

    vts_range_chk #(.VCODE_W(VCODE_W)) u_range (
        .code     (bus_wdata[VCODE_W-1:0]),
        .vmin     (vmin),
        .vmax     (vmax),
        .in_range (in_range)
    );

    vts_fsm #(.VCODE_W(VCODE_W), .DIV_W(DIV_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_wr      (req_wr),
        .req_code    (bus_wdata[VCODE_W-1:0]),
        .req_div     (bus_wdata[HI_FIELD_LSB +: DIV_W]),
        .seq_enable  (seq_enable),
        .in_range    (in_range),
        .volt_stable (volt_stable),
        .volt_req    (volt_req),
        .tgt_q       (tgt_q),
        .div_pend_q  (div_pend_q),
        .div_load    (div_load),
        .done_set    (done_set),
        .bounds_set  (bounds_set),
        .err_set     (err_set)
    );

    vts_regfile #(.VCODE_W(VCODE_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .tgt_q      (tgt_q),
        .div_pend_q (div_pend_q),
        .div_load   (div_load),
        .done_set   (done_set),
        .bounds_set (bounds_set),
        .err_set    (err_set),
        .req_wr     (req_wr),
        .seq_enable (seq_enable),
        .vmin       (vmin),
        .vmax       (vmax),
        .clk_div    (clk_div),
        .irq        (irq)
    );

    assign volt_code = tgt_q;

    // divider moves only in the cycle before DONE
    p_div_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_div != $past(clk_div)) |-> done_set);

endmodule

// File: tb/vtrans_seq_test.sv
module vtrans_seq_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        volt_stable;
    logic        volt_req;
    logic [7:0]  volt_code;
    logic [4:0]  clk_div;
    logic        irq;

    int checks = 0;
    int errors = 0;

    vtrans_seq uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .volt_stable(volt_stable),
        .volt_req(volt_req), .volt_code(volt_code), .clk_div(clk_div), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    localparam logic [31:0] M_IRQ = 32'h0040_0420;
    int          m_phase;
    logic [31:0] m_ctrl, m_en, m_stat, m_lim;
    logic [7:0]  m_tgt;
    logic [4:0]  m_pend, m_div;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_ctrl = 0; m_en = 0; m_stat = 0;
            m_lim = 32'h00FF_0000; m_tgt = 0; m_pend = 0; m_div = 5'd1;
        end else begin
            logic [31:0] sets, clr;
            int nxt;
            logic req;
            req  = bus_wr && bus_addr == 3'd3;
            sets = 0;
            nxt  = m_phase;
            if (m_phase == 4) sets[10] = 1'b1;
            if (req && m_phase != 0) sets[5] = 1'b1;
            case (m_phase)
                0: if (req && m_ctrl[0] && m_ctrl[11]) begin
                       if (bus_wdata[7:0] >= m_lim[7:0] && bus_wdata[7:0] <= m_lim[23:16]) begin
                           nxt = 1; m_tgt = bus_wdata[7:0]; m_pend = bus_wdata[20:16];
                       end else sets[22] = 1'b1;
                   end
                1: nxt = 2;
                2: if (volt_stable) nxt = 3;
                3: begin m_div = m_pend; nxt = 4; end
                default: nxt = 0;
            endcase
            clr = (bus_wr && bus_addr == 3'd2) ? (bus_wdata & M_IRQ) : 32'h0;
            m_stat = (m_stat & ~clr) | sets;
            if (bus_wr && bus_addr == 3'd0) m_ctrl = bus_wdata & 32'h0000_0801;
            if (bus_wr && bus_addr == 3'd1) m_en   = bus_wdata & M_IRQ;
            if (bus_wr && bus_addr == 3'd4) m_lim  = bus_wdata & 32'h00FF_00FF;
            m_phase = nxt;
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return m_en;
            3'd2: return m_stat;
            3'd3: return {11'd0, m_pend, 8'd0, m_tgt};
            3'd4: return m_lim;
            3'd5: return {27'd0, m_div};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock with per-cycle model comparison
    task automatic cyc();
        @(posedge clk);
        #(CLK_P/4);
        chk({31'd0, volt_req}, {31'd0, m_phase == 1}, "R3 volt_req vs model");
        chk({24'd0, volt_code}, {24'd0, m_tgt}, "R3 volt_code vs model");
        chk({27'd0, clk_div}, {27'd0, m_div}, "R5 clk_div vs model");
        chk({31'd0, irq}, {31'd0, |(m_stat & m_en)}, "R8 irq vs model");
        chk(bus_rdata, m_read(bus_addr), "R12 readback vs model");
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata, exp, tag);
    endtask

    initial begin
        #(CLK_P * 20000);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; volt_stable = 0;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk({27'd0, clk_div}, 32'd1, "R1 divider reset");
        chk({31'd0, irq}, 32'd0, "R1 irq reset");
        rd(3'd2, 32'h0, "R1 status reset");
        rd(3'd4, 32'h00FF_0000, "R1 window reset");

        // R2 request ignored without both enables
        wr(3'd3, 32'h0003_0040);
        chk({31'd0, volt_req}, 32'd0, "R2 no start when disabled");
        wr(3'd0, 32'h0000_0001);
        wr(3'd3, 32'h0003_0040);
        chk({31'd0, volt_req}, 32'd0, "R2 no start with one enable");
        rd(3'd3, 32'h0, "R2 request readback unchanged");
        rd(3'd2, 32'h0, "R2 status unchanged");

        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, 32'h0000_0801, "R2 control bits kept");
        wr(3'd1, 32'h0040_0420);
        wr(3'd4, 32'h00C0_0020);

        // R3/R4/R5/R6 normal change
        wr(3'd3, 32'h0003_0050);
        chk({31'd0, volt_req}, 32'd1, "R3 pulse after write");
        chk({24'd0, volt_code}, 32'h50, "R3 target on volt_code");
        cyc();
        chk({31'd0, volt_req}, 32'd0, "R3 pulse is one cycle");
        repeat (3) cyc();
        chk({27'd0, clk_div}, 32'd1, "R4 held while unsettled");
        volt_stable = 1'b1; cyc(); volt_stable = 1'b0;
        chk({27'd0, clk_div}, 32'd1, "R5 divider not yet loaded");
        cyc();
        chk({27'd0, clk_div}, 32'd3, "R5 divider loaded");
        chk({31'd0, irq}, 32'd0, "R6 done not yet set");
        cyc();
        rd(3'd2, 32'h0000_0400, "R6 done status");
        chk({31'd0, irq}, 32'd1, "R8 irq on done");

        // R7 write-one-to-clear
        wr(3'd2, 32'h0);
        rd(3'd2, 32'h0000_0400, "R7 zero write no effect");
        wr(3'd2, 32'h0000_0400);
        rd(3'd2, 32'h0, "R7 one clears");
        chk({31'd0, irq}, 32'd0, "R8 irq drops after clear");

        // R4 settled flag outside WAIT_STABLE ignored
        volt_stable = 1'b1; cyc(); cyc(); volt_stable = 1'b0;
        chk({27'd0, clk_div}, 32'd3, "R4 stable in idle ignored");
        chk({31'd0, volt_req}, 32'd0, "R4 no pulse from stable");

        // R9 bounds
        wr(3'd3, 32'h0007_0010);
        chk({31'd0, volt_req}, 32'd0, "R9 below min no start");
        rd(3'd2, 32'h0040_0000, "R9 bounds status");
        chk({31'd0, irq}, 32'd1, "R8 irq on bounds");
        wr(3'd2, 32'h0040_0000);
        wr(3'd3, 32'h0007_00C1);
        rd(3'd2, 32'h0040_0000, "R9 above max");
        wr(3'd2, 32'h0040_0000);
        wr(3'd1, 32'h0000_0420);
        chk({31'd0, irq}, 32'd0, "R8 masked bounds");

        // R9 boundary accepted, R10 busy request
        wr(3'd3, 32'h0002_00C0);
        chk({31'd0, volt_req}, 32'd1, "R9 max accepted");
        cyc();
        wr(3'd3, 32'h0009_0030);
        chk({24'd0, volt_code}, 32'hC0, "R10 busy request ignored");
        rd(3'd2, 32'h0000_0020, "R10 error status");
        volt_stable = 1'b1; cyc(); volt_stable = 1'b0;
        cyc(); cyc();
        chk({27'd0, clk_div}, 32'd2, "R10 divider from first request");
        rd(3'd2, 32'h0000_0420, "R10 error sticky");
        wr(3'd2, 32'h0000_0420);

        // R11 set and clear in same cycle
        wr(3'd3, 32'h0004_0020);
        cyc();
        volt_stable = 1'b1; cyc(); volt_stable = 1'b0;
        cyc();
        wr(3'd2, 32'h0000_0400);
        rd(3'd2, 32'h0000_0400, "R11 set wins");
        chk({27'd0, clk_div}, 32'd4, "R5 min target divider");

        // R12 readbacks
        rd(3'd5, 32'd4, "R12 divider readback");
        rd(3'd3, 32'h0004_0020, "R12 request readback");
        rd(3'd7, 32'h0, "R12 unmapped");
        rd(3'd6, 32'h0, "R12 unmapped");
        cyc();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule